// File: doc/BRIEF.md
# Victim Line Buffer with Swap

This block is a small fully associative store that sits beside a main cache and catches the lines that cache throws out. Every line the cache evicts is written into one of its slots together with its full line address and a dirty flag. The cache can probe the buffer with the same address it presents to its own tag arrays. The answer comes back combinationally in that same cycle, so both lookups run side by side.

When the cache misses but the buffer hits, the cache raises its eviction in the same cycle with a swap flag. The buffer then hands over the hit line, and the cache's outgoing victim takes the slot that line leaves behind. The contents are exchanged instead of being queued in order. Slots are reused in least-recently-used order. When a full buffer takes a plain insert, the oldest line leaves: a dirty line goes out on a one-deep writeback port, and a clean one is discarded. While that port is stalled, the buffer stops taking plain inserts.

Top module: `victim_swap_buffer`

## Requirements
- R1: After reset no slot holds a line: a lookup of any address, including address 0, reports no hit, `wbValid` is 0 and `evictReady` is 1.
- R2: With `lookupValid` high, `lookupHit` and `lookupData` reflect the stored line whose full line address equals `lookupAddr`, in the same cycle and with no clock edge in between; an address not held gives `lookupHit` 0.
- R3: While any slot is empty, an accepted plain insert fills the empty slot with the lowest index and produces no writeback.
- R4: When all slots are full, an accepted plain insert replaces the least recently used line. A line that is inserted and never touched again leaves after exactly ENTRIES further inserts (four by default).
- R5: A swap happens when `evictValid` and `evictSwap` are high and the lookup in the same cycle hits. `lookupData` returns the hit line, the evicted line takes over that slot as most recently used, and the old address no longer hits. No writeback is produced, and the swap proceeds even while `evictReady` is low.
- R6: A lookup hit in a cycle with `evictValid` low counts as a use and makes that line the most recently used, so it outlives older untouched lines.
- R7: A dirty line pushed out by replacement appears on `wbValid`/`wbAddr`/`wbData` in the cycle after the insert; a clean line pushed out raises no writeback.
- R8: Once `wbValid` is high it stays high with `wbAddr` and `wbData` unchanged until a cycle with `wbReady` high. After such a cycle it falls unless a new writeback is loaded.
- R9: `evictReady` is low exactly while `wbValid` is high and `wbReady` is low. A plain insert offered in such a cycle is dropped and changes no stored line.
- R10: With `lookupValid` low, `lookupHit` is 0 whatever the buffer holds.
- R11: An eviction marked `evictSwap` whose lookup misses is handled as a plain insert, including LRU replacement and writeback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| lookupValid | input | 1 | Probe request this cycle |
| lookupAddr | input | ADDR_W | Full line address being probed |
| lookupHit | output | 1 | Probe found the line (combinational) |
| lookupData | output | LINE_W | Line contents; meaningful only with lookupHit |
| evictValid | input | 1 | Cache is evicting a line this cycle |
| evictSwap | input | 1 | The eviction pairs with this cycle's probe for a swap |
| evictAddr | input | ADDR_W | Full line address of the evicted line |
| evictData | input | LINE_W | Contents of the evicted line |
| evictDirty | input | 1 | Evicted line is modified |
| evictReady | output | 1 | Plain inserts are accepted this cycle |
| wbValid | output | 1 | A dirty line waits to be written to memory |
| wbAddr | output | ADDR_W | Line address of the pending writeback |
| wbData | output | LINE_W | Contents of the pending writeback |
| wbReady | input | 1 | Memory side takes the writeback this cycle |

## Verification
The assertions assume that the cache never inserts a line address the buffer already holds. Because of this, at most one slot can match a probe. They also assume that inputs change only between clock edges. The bench uses a distinct line address for every insert between resets, and changes its inputs only on falling edges. A line's data is derived from its address, so any returned value shows which line it came from. The bench keeps `wbReady` high except in the stall test, where it deliberately offers a plain insert and a swap while `evictReady` is low.

// File: rtl/vb_pkg.sv
package vb_pkg;

  // Widest slot index supported; the top checks ENTRIES against it.
  localparam int unsigned SLOT_IDX_W = 4;

  typedef logic [SLOT_IDX_W-1:0] slot_idx_t;

  // Strobes from control to datapath, one set per cycle.
  typedef struct packed {
    logic      wrEn;    // write the eviction port into slot wrIdx
    slot_idx_t wrIdx;   // target slot of a fill (insert or swap)
    logic      wbLoad;  // copy slot wrIdx into the writeback register first
    slot_idx_t rdIdx;   // slot that drives lookupData
  } vb_strobe_t;

endpackage

// File: rtl/vb_datapath.sv
module vb_datapath
  import vb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned LINE_W  = 32,
  parameter int unsigned ENTRIES = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  vb_strobe_t          strobe,
  input  logic [ADDR_W-1:0]   lookupAddr,
  input  logic [ADDR_W-1:0]   evictAddr,
  input  logic [LINE_W-1:0]   evictData,
  input  logic                evictDirty,
  output logic [ENTRIES-1:0]  matchVec,
  output logic [ENTRIES-1:0]  dirtyVec,
  output logic [LINE_W-1:0]   lookupData,
  output logic [ADDR_W-1:0]   wbAddr,
  output logic [LINE_W-1:0]   wbData
);

  logic [ADDR_W-1:0] slotAddrQ  [ENTRIES];
  logic [LINE_W-1:0] slotDataQ  [ENTRIES];
  logic              slotDirtyQ [ENTRIES];

  logic [ADDR_W-1:0] outAddr;
  logic [LINE_W-1:0] outData;
  logic [ADDR_W-1:0] wbAddrQ;
  logic [LINE_W-1:0] wbDataQ;

  // One storage slot per entry, each with its own comparator.
  for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
    assign matchVec[s] = (slotAddrQ[s] == lookupAddr);
    assign dirtyVec[s] = slotDirtyQ[s];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotAddrQ[s]  <= '0;
        slotDataQ[s]  <= '0;
        slotDirtyQ[s] <= 1'b0;
      end else if (strobe.wrEn && (strobe.wrIdx == slot_idx_t'(s))) begin
        slotAddrQ[s]  <= evictAddr;
        slotDataQ[s]  <= evictData;
        slotDirtyQ[s] <= evictDirty;
      end
    end
  end

  // Read mux for the probe and for the line about to be displaced.
  always_comb begin
    lookupData = '0;
    outAddr    = '0;
    outData    = '0;
    for (int s = 0; s < ENTRIES; s++) begin
      if (strobe.rdIdx == slot_idx_t'(s)) lookupData = slotDataQ[s];
      if (strobe.wrIdx == slot_idx_t'(s)) begin
        outAddr = slotAddrQ[s];
        outData = slotDataQ[s];
      end
    end
  end

  // The old contents are captured on the same edge that overwrites the slot.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbAddrQ <= '0;
      wbDataQ <= '0;
    end else if (strobe.wbLoad) begin
      wbAddrQ <= outAddr;
      wbDataQ <= outData;
    end
  end

  assign wbAddr = wbAddrQ;
  assign wbData = wbDataQ;

endmodule

// File: rtl/vb_ctrl.sv
module vb_ctrl
  import vb_pkg::*;
#(
  parameter int unsigned ENTRIES = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lookupValid,
  input  logic               evictValid,
  input  logic               evictSwap,
  input  logic               wbReady,
  input  logic [ENTRIES-1:0] matchVec,
  input  logic [ENTRIES-1:0] dirtyVec,
  output logic               lookupHit,
  output logic               evictReady,
  output logic               wbValid,
  output vb_strobe_t         strobe
);

  localparam int unsigned AGE_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [AGE_W-1:0] AGE_OLDEST = AGE_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] validQ;
  logic [AGE_W-1:0]   ageQ [ENTRIES];
  logic               wbValidQ;

  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] lruMask;
  slot_idx_t          hitIdx;
  slot_idx_t          freeIdx;
  slot_idx_t          lruIdx;
  slot_idx_t          touchIdx;
  logic [AGE_W-1:0]   touchAge;
  logic               freeFound;
  logic               lruDirty;
  logic               swapDo;
  logic               insDo;
  logic               fillDo;
  logic               touchDo;
  logic               wbLoad;

  assign hitVec    = matchVec & validQ;
  assign lookupHit = lookupValid && (|hitVec);
  assign freeFound = ~(&validQ);

  // Encoders: hit slot, lowest empty slot, oldest slot.
  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    lruIdx  = '0;
    for (int s = ENTRIES - 1; s >= 0; s--) begin
      lruMask[s] = (ageQ[s] == AGE_OLDEST);
      if (hitVec[s])   hitIdx  = slot_idx_t'(s);
      if (!validQ[s])  freeIdx = slot_idx_t'(s);
      if (lruMask[s])  lruIdx  = slot_idx_t'(s);
    end
  end

  assign lruDirty   = |(lruMask & dirtyVec & validQ);
  assign evictReady = !(wbValidQ && !wbReady);

  // Swap wins over a plain insert and ignores backpressure.
  assign swapDo  = evictValid && evictSwap && lookupHit;
  assign insDo   = evictValid && !swapDo && evictReady;
  assign fillDo  = swapDo || insDo;
  assign touchDo = fillDo || (lookupHit && !evictValid);
  assign wbLoad  = insDo && !freeFound && lruDirty;

  always_comb begin
    if (swapDo)      touchIdx = hitIdx;
    else if (insDo)  touchIdx = freeFound ? freeIdx : lruIdx;
    else             touchIdx = hitIdx;
  end

  always_comb begin
    touchAge = '0;
    for (int s = 0; s < ENTRIES; s++) begin
      if (touchIdx == slot_idx_t'(s)) touchAge = ageQ[s];
    end
  end

  // Ages form a permutation: the touched slot becomes 0, younger ones age by one.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= '0;
      for (int s = 0; s < ENTRIES; s++) ageQ[s] <= AGE_W'(s);
    end else if (touchDo) begin
      for (int s = 0; s < ENTRIES; s++) begin
        if (touchIdx == slot_idx_t'(s)) begin
          ageQ[s] <= '0;
          if (fillDo) validQ[s] <= 1'b1;
        end else if (ageQ[s] < touchAge) begin
          ageQ[s] <= ageQ[s] + AGE_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        wbValidQ <= 1'b0;
    else if (wbLoad)  wbValidQ <= 1'b1;
    else if (wbReady) wbValidQ <= 1'b0;
  end

  assign wbValid       = wbValidQ;
  assign strobe.wrEn   = fillDo;
  assign strobe.wrIdx  = touchIdx;
  assign strobe.wbLoad = wbLoad;
  assign strobe.rdIdx  = hitIdx;

  // At most one valid slot may match a probe.
  assert_hit_unique_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // Exactly one slot carries the oldest age at any time.
  assert_lru_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(lruMask) == 1);

  // A full buffer stays full across a replacement.
  assert_full_stays_R4: assert property (@(posedge clk) disable iff (!rstN)
    (insDo && (&validQ)) |=> (&validQ));

  // A stalled writeback is not lost.
  assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValidQ && !wbReady) |=> wbValidQ);

  // A swap never creates a writeback.
  assert_swap_no_wb_R5: assert property (@(posedge clk) disable iff (!rstN)
    (swapDo && (!wbValidQ || wbReady)) |=> !wbValidQ);

endmodule

// File: rtl/victim_swap_buffer.sv
module victim_swap_buffer
  import vb_pkg::*;
#(
  parameter int unsigned ADDR_W  = 12,
  parameter int unsigned LINE_W  = 32,
  parameter int unsigned ENTRIES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lookupValid,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              lookupHit,
  output logic [LINE_W-1:0] lookupData,
  input  logic              evictValid,
  input  logic              evictSwap,
  input  logic [ADDR_W-1:0] evictAddr,
  input  logic [LINE_W-1:0] evictData,
  input  logic              evictDirty,
  output logic              evictReady,
  output logic              wbValid,
  output logic [ADDR_W-1:0] wbAddr,
  output logic [LINE_W-1:0] wbData,
  input  logic              wbReady
);

  initial begin
    if (ENTRIES < 2 || ENTRIES > (1 << SLOT_IDX_W))
      $error("victim_swap_buffer: ENTRIES out of supported range");
  end

  vb_strobe_t         strobe;
  logic [ENTRIES-1:0] matchVec;
  logic [ENTRIES-1:0] dirtyVec;

  vb_ctrl #(
    .ENTRIES (ENTRIES)
  ) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .lookupValid (lookupValid),
    .evictValid  (evictValid),
    .evictSwap   (evictSwap),
    .wbReady     (wbReady),
    .matchVec    (matchVec),
    .dirtyVec    (dirtyVec),
    .lookupHit   (lookupHit),
    .evictReady  (evictReady),
    .wbValid     (wbValid),
    .strobe      (strobe)
  );

  vb_datapath #(
    .ADDR_W  (ADDR_W),
    .LINE_W  (LINE_W),
    .ENTRIES (ENTRIES)
  ) data_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .lookupAddr (lookupAddr),
    .evictAddr  (evictAddr),
    .evictData  (evictData),
    .evictDirty (evictDirty),
    .matchVec   (matchVec),
    .dirtyVec   (dirtyVec),
    .lookupData (lookupData),
    .wbAddr     (wbAddr),
    .wbData     (wbData)
  );

  // Writeback payload holds still while the memory side stalls.
  assert_wb_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && !wbReady) |=> ($stable(wbAddr) && $stable(wbData)));

endmodule

// File: tb/victim_swap_buffer_tb_top.sv
module victim_swap_buffer_tb_top;

  localparam int unsigned ADDR_W  = 12;
  localparam int unsigned LINE_W  = 32;
  localparam int unsigned ENTRIES = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              lookupValid = 1'b0;
  logic [ADDR_W-1:0] lookupAddr = '0;
  logic              lookupHit;
  logic [LINE_W-1:0] lookupData;
  logic              evictValid = 1'b0;
  logic              evictSwap = 1'b0;
  logic [ADDR_W-1:0] evictAddr = '0;
  logic [LINE_W-1:0] evictData = '0;
  logic              evictDirty = 1'b0;
  logic              evictReady;
  logic              wbValid;
  logic [ADDR_W-1:0] wbAddr;
  logic [LINE_W-1:0] wbData;
  logic              wbReady = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  victim_swap_buffer #(
    .ADDR_W (ADDR_W), .LINE_W (LINE_W), .ENTRIES (ENTRIES)
  ) dut_i (
    .clk (clk), .rstN (rstN),
    .lookupValid (lookupValid), .lookupAddr (lookupAddr),
    .lookupHit (lookupHit), .lookupData (lookupData),
    .evictValid (evictValid), .evictSwap (evictSwap),
    .evictAddr (evictAddr), .evictData (evictData), .evictDirty (evictDirty),
    .evictReady (evictReady),
    .wbValid (wbValid), .wbAddr (wbAddr), .wbData (wbData), .wbReady (wbReady)
  );

  function automatic logic [LINE_W-1:0] lineOf(input logic [ADDR_W-1:0] a);
    return {a, 20'h5A5C3};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // op: 0 plain insert, 1 lookup only, 2 lookup plus eviction flagged as swap
  typedef struct packed {
    logic [1:0]        op;
    logic [ADDR_W-1:0] lkAddr;
    logic [ADDR_W-1:0] evAddr;
    logic              evDirty;
    logic              expHit;
    logic              expWb;
    logic [ADDR_W-1:0] expWbAddr;
    logic [7:0]        req;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 12'h000, 12'h100, 1'b1, 1'b0, 1'b0, 12'h000, 8'd3},  // R3 fill slot 0
    '{2'd0, 12'h000, 12'h200, 1'b0, 1'b0, 1'b0, 12'h000, 8'd3},  // R3
    '{2'd0, 12'h000, 12'h300, 1'b1, 1'b0, 1'b0, 12'h000, 8'd3},  // R3
    '{2'd0, 12'h000, 12'h400, 1'b0, 1'b0, 1'b0, 12'h000, 8'd3},  // R3 now full
    '{2'd1, 12'h300, 12'h000, 1'b0, 1'b1, 1'b0, 12'h000, 8'd2},  // R2 hit, touches 300
    '{2'd1, 12'h555, 12'h000, 1'b0, 1'b0, 1'b0, 12'h000, 8'd2},  // R2 miss
    '{2'd0, 12'h000, 12'h500, 1'b1, 1'b0, 1'b1, 12'h100, 8'd7},  // R7 dirty 100 out
    '{2'd0, 12'h000, 12'h600, 1'b0, 1'b0, 1'b0, 12'h000, 8'd7},  // R7 clean 200 dropped
    '{2'd0, 12'h000, 12'h700, 1'b0, 1'b0, 1'b0, 12'h000, 8'd6},  // R6 400 goes, 300 stays
    '{2'd1, 12'h400, 12'h000, 1'b0, 1'b0, 1'b0, 12'h000, 8'd6},  // R6
    '{2'd1, 12'h300, 12'h000, 1'b0, 1'b1, 1'b0, 12'h000, 8'd6},  // R6
    '{2'd2, 12'h600, 12'h800, 1'b1, 1'b1, 1'b0, 12'h000, 8'd5},  // R5 swap
    '{2'd1, 12'h600, 12'h000, 1'b0, 1'b0, 1'b0, 12'h000, 8'd5},  // R5 old gone
    '{2'd1, 12'h800, 12'h000, 1'b0, 1'b1, 1'b0, 12'h000, 8'd5},  // R5 victim held
    '{2'd2, 12'h999, 12'h900, 1'b0, 1'b0, 1'b1, 12'h500, 8'd11}, // R11 swap miss
    '{2'd1, 12'h900, 12'h000, 1'b0, 1'b1, 1'b0, 12'h000, 8'd11}  // R11
  };

  // Called just after a falling edge; returns just after the next one.
  task automatic step(input logic [1:0] op, input logic [ADDR_W-1:0] lk,
                      input logic [ADDR_W-1:0] ev, input logic dirty,
                      input logic expHit, input logic expWb,
                      input logic [ADDR_W-1:0] expWbAddr, input string req);
    lookupValid = (op != 2'd0);
    lookupAddr  = lk;
    evictValid  = (op != 2'd1);
    evictSwap   = (op == 2'd2);
    evictAddr   = ev;
    evictData   = lineOf(ev);
    evictDirty  = dirty;
    #1;
    if (op != 2'd0) begin
      check(lookupHit == expHit, req, 64'(lookupHit), 64'(expHit));
      if (expHit) check(lookupData == lineOf(lk), req, 64'(lookupData), 64'(lineOf(lk)));
    end
    @(posedge clk);
    @(negedge clk);
    lookupValid = 1'b0;
    evictValid  = 1'b0;
    evictSwap   = 1'b0;
    #1;
    check(wbValid == expWb, req, 64'(wbValid), 64'(expWb));
    if (expWb) begin
      check(wbAddr == expWbAddr, req, 64'(wbAddr), 64'(expWbAddr));
      check(wbData == lineOf(expWbAddr), req, 64'(wbData), 64'(lineOf(expWbAddr)));
    end
  endtask

  task automatic applyReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    applyReset();
    // R1 reset state
    lookupValid = 1'b1;
    lookupAddr  = '0;
    #1;
    check(lookupHit == 1'b0, "R1", 64'(lookupHit), 64'd0);
    check(wbValid == 1'b0, "R1", 64'(wbValid), 64'd0);
    check(evictReady == 1'b1, "R1", 64'(evictReady), 64'd1);
    lookupValid = 1'b0;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      step(VECS[v].op, VECS[v].lkAddr, VECS[v].evAddr, VECS[v].evDirty,
           VECS[v].expHit, VECS[v].expWb, VECS[v].expWbAddr,
           $sformatf("R%0d", VECS[v].req));
    end

    // R4: a line leaves exactly ENTRIES inserts later, empty and full buffer
    applyReset();
    step(2'd0, 12'h0, 12'h010, 1'b1, 1'b0, 1'b0, 12'h0, "R4");
    step(2'd0, 12'h0, 12'h020, 1'b0, 1'b0, 1'b0, 12'h0, "R4");
    step(2'd0, 12'h0, 12'h030, 1'b0, 1'b0, 1'b0, 12'h0, "R4");
    step(2'd0, 12'h0, 12'h040, 1'b0, 1'b0, 1'b0, 12'h0, "R4");
    step(2'd0, 12'h0, 12'h050, 1'b1, 1'b0, 1'b1, 12'h010, "R4");
    step(2'd0, 12'h0, 12'h060, 1'b0, 1'b0, 1'b0, 12'h0, "R4");
    step(2'd0, 12'h0, 12'h070, 1'b0, 1'b0, 1'b0, 12'h0, "R4");
    step(2'd0, 12'h0, 12'h080, 1'b0, 1'b0, 1'b0, 12'h0, "R4");
    step(2'd0, 12'h0, 12'h090, 1'b0, 1'b0, 1'b1, 12'h050, "R4");

    // R8 / R9: stalled writeback
    applyReset();
    wbReady = 1'b0;
    step(2'd0, 12'h0, 12'h0A1, 1'b1, 1'b0, 1'b0, 12'h0, "R3");
    step(2'd0, 12'h0, 12'h0A2, 1'b1, 1'b0, 1'b0, 12'h0, "R3");
    step(2'd0, 12'h0, 12'h0A3, 1'b1, 1'b0, 1'b0, 12'h0, "R3");
    step(2'd0, 12'h0, 12'h0A4, 1'b1, 1'b0, 1'b0, 12'h0, "R3");
    step(2'd0, 12'h0, 12'h0A5, 1'b1, 1'b0, 1'b1, 12'h0A1, "R7");
    check(evictReady == 1'b0, "R9", 64'(evictReady), 64'd0);
    // plain insert offered while stalled: dropped, writeback held
    step(2'd0, 12'h0, 12'h0A6, 1'b1, 1'b0, 1'b1, 12'h0A1, "R8");
    // swap proceeds despite backpressure
    step(2'd2, 12'h0A3, 12'h0B3, 1'b0, 1'b1, 1'b1, 12'h0A1, "R5");
    check(evictReady == 1'b0, "R9", 64'(evictReady), 64'd0);
    wbReady = 1'b1;
    #1;
    check(evictReady == 1'b1, "R9", 64'(evictReady), 64'd1);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(wbValid == 1'b0, "R8", 64'(wbValid), 64'd0);
    step(2'd1, 12'h0A6, 12'h0, 1'b0, 1'b0, 1'b0, 12'h0, "R9");
    step(2'd1, 12'h0B3, 12'h0, 1'b0, 1'b1, 1'b0, 12'h0, "R5");
    step(2'd1, 12'h0A2, 12'h0, 1'b0, 1'b1, 1'b0, 12'h0, "R9");

    // R10: probe gated by its valid
    lookupValid = 1'b0;
    lookupAddr  = 12'h0A2;
    #1;
    check(lookupHit == 1'b0, "R10", 64'(lookupHit), 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule